// File: doc/BRIEF.md
# Mode-Switched Sinc Interpolator

This block sits between a 4x interpolating FIR stage and a 1-bit sigma-delta modulator in an audio DAC datapath. It takes 16-bit signed samples and raises them to a fixed rate of 64 times the base sample rate using a second-order cascaded integrator-comb (sinc-squared) interpolator. The block is clocked from the 384x master clock. A free-running divide-by-6 counter produces the 64x output strobe.

The upstream stage delivers samples at 4x the base rate in normal mode and at 8x in double mode. The block therefore switches its interpolation ratio between 16 and 8 with the `double_mode` pin, so the output rate never changes. Each new sample passes through the comb section, is injected into the integrators on the next output strobe, and zeros are injected on the other strobes. The output is scaled by a mode-dependent right shift so that the DC gain is exactly one. The result is linear interpolation between adjacent input samples, which strongly attenuates images at multiples of the input rate.

The upstream stage must present exactly one sample every R output strobes. When the mode pin changes, the whole datapath is cleared and restarts from zero.

Top module: `sinc_interp`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and `out_data` are 0 after that edge.
- R2: `out_valid` is high for one clock in every 6 clocks. The spacing is the same in both modes and is not disturbed by a mode change.
- R3: With `double_mode`=0 the ratio is R=16. After a reset, a constant input A yields outputs floor(A*(k+1)/16) for output slots k=0..15, then exactly A.
- R4: With `double_mode`=1 the ratio is R=8. After a reset, a constant input A yields floor(A*(k+1)/8) for k=0..7, then exactly A.
- R5: A sample taken while `in_valid`=1 is injected on the first strobe after it. For input j injected at output slot jR, output slot m equals floor(sum_j x[j]*h(m-jR)/R). Here h(k)=k+1 for 0<=k<R, h(k)=2R-1-k for R<=k<=2R-2, and h is 0 elsewhere.
- R6: DC gain is unity in both modes: settled full-scale inputs 32767 and -32768 are reproduced exactly.
- R7: When the value of `double_mode` differs from its value at the previous clock edge, all integrator, comb and output state is cleared. `out_data` is 0 after that edge, and the response then starts afresh.
- R8: `out_data` changes only at the edge that raises `out_valid` or at a clearing edge. Otherwise it holds.
- R9: `in_data` is ignored while `in_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 384x master clock |
| rst | input | 1 | Synchronous active-high reset |
| double_mode | input | 1 | 0: input at 4x, ratio 16; 1: input at 8x, ratio 8 |
| in_valid | input | 1 | One-cycle qualifier for `in_data` |
| in_data | input | 16 | Signed input sample |
| out_valid | output | 1 | 64x output strobe |
| out_data | output | 16 | Signed interpolated output sample |

## Verification
A wrong value in a comb delay or in an integrator is permanent. With no leak, the error appears on the next strobe as a ramp or an offset that never decays. A check of each output slot against the triangular-kernel sum exposes it within one input period of 16 or 8 strobes. A wrong shift for a mode shows up as a settled value that is off by a factor of two, and a strobe-counter fault shows up as a mis-spaced `out_valid` within 6 clocks. Clearing on a mode change is observed one clock after the pin toggles, as `out_data` falling to zero.

// File: rtl/sinc_pkg.sv
package sinc_pkg;
  localparam int SAMPLE_W   = 16;
  localparam int CIC_ORDER  = 2;
  localparam int LOG_R_NORM = 4;
  localparam int LOG_R_DBL  = 3;
  localparam int OS_DIV     = 6;

  typedef enum logic {
    RATE_NORMAL = 1'b0,
    RATE_DOUBLE = 1'b1
  } rate_mode_e;
endpackage

// File: rtl/sinc_strobe_gen.sv
module sinc_strobe_gen #(
  parameter int DIV = 6
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = (cnt_q == LAST) && !rst;
endmodule

// File: rtl/sinc_comb_chain.sv
module sinc_comb_chain #(
  parameter int W     = 24,
  parameter int ORDER = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                load,
  input  logic signed [W-1:0] din,
  output logic signed [W-1:0] dout
);
  logic signed [W-1:0] stg [ORDER+1];

  assign stg[0] = din;

  for (genvar i = 0; i < ORDER; i++) begin : g_stage
    logic signed [W-1:0] dly_q;

    always_ff @(posedge clk) begin
      if (rst || clr) begin
        dly_q <= '0;
      end else if (load) begin
        dly_q <= stg[i];
      end
    end

    assign stg[i+1] = stg[i] - dly_q;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      dout <= '0;
    end else if (load) begin
      dout <= stg[ORDER];
    end
  end
endmodule

// File: rtl/sinc_integ_chain.sv
module sinc_integ_chain #(
  parameter int W     = 24,
  parameter int ORDER = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                step,
  input  logic signed [W-1:0] inj,
  output logic signed [W-1:0] sum_next
);
  logic signed [W-1:0] nxt [ORDER+1];

  assign nxt[0] = inj;

  for (genvar i = 0; i < ORDER; i++) begin : g_stage
    logic signed [W-1:0] acc_q;

    assign nxt[i+1] = acc_q + nxt[i];

    always_ff @(posedge clk) begin
      if (rst || clr) begin
        acc_q <= '0;
      end else if (step) begin
        acc_q <= nxt[i+1];
      end
    end
  end

  assign sum_next = nxt[ORDER];
endmodule

// File: rtl/sinc_interp.sv
module sinc_interp
  import sinc_pkg::*;
#(
  parameter int IN_W   = SAMPLE_W,
  parameter int ORDER  = CIC_ORDER,
  parameter int LOG_RN = LOG_R_NORM,
  parameter int LOG_RD = LOG_R_DBL,
  parameter int DIV    = OS_DIV
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            double_mode,
  input  logic            in_valid,
  input  logic [IN_W-1:0] in_data,
  output logic            out_valid,
  output logic [IN_W-1:0] out_data
);
  localparam int WW    = IN_W + ORDER * LOG_RN;
  localparam int SH_N  = (ORDER - 1) * LOG_RN;
  localparam int SH_D  = (ORDER - 1) * LOG_RD;

  rate_mode_e          mode_q;
  logic                clr;
  logic                tick;
  logic                pend_q;
  logic                load;
  logic signed [WW-1:0] din_ext;
  logic signed [WW-1:0] comb_q;
  logic signed [WW-1:0] inj;
  logic signed [WW-1:0] sum_next;

  assign clr     = (rate_mode_e'(double_mode) != mode_q);
  assign load    = in_valid && !clr;
  assign din_ext = WW'($signed(in_data));
  assign inj     = pend_q ? comb_q : '0;

  sinc_strobe_gen #(.DIV(DIV)) u_strobe (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  sinc_comb_chain #(.W(WW), .ORDER(ORDER)) u_comb (
    .clk  (clk),
    .rst  (rst),
    .clr  (clr),
    .load (load),
    .din  (din_ext),
    .dout (comb_q)
  );

  sinc_integ_chain #(.W(WW), .ORDER(ORDER)) u_integ (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .step     (tick),
    .inj      (inj),
    .sum_next (sum_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= rate_mode_e'(double_mode);
    end else begin
      mode_q <= rate_mode_e'(double_mode);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pend_q <= 1'b0;
    end else if (in_valid) begin
      pend_q <= 1'b1;
    end else if (tick) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= tick;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      out_data <= '0;
    end else if (tick) begin
      if (mode_q == RATE_DOUBLE) begin
        out_data <= IN_W'(sum_next >>> SH_D);
      end else begin
        out_data <= IN_W'(sum_next >>> SH_N);
      end
    end
  end
endmodule

// File: rtl/sinc_interp_chk.sv
module sinc_interp_chk #(
  parameter int IN_W = 16,
  parameter int DIV  = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            double_mode,
  input logic            out_valid,
  input logic [IN_W-1:0] out_data
);
  localparam int GW = $clog2(DIV + 1) + 1;

  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (out_valid) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q != {GW{1'b1}}) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && out_data == '0));

  // R2
  strobe_period_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_q && out_valid) |-> (gap_q == GW'(DIV - 1)));

  // R2
  strobe_late_chk: assert property (@(posedge clk) disable iff (rst)
    (seen_q && !out_valid) |-> (gap_q < GW'(DIV - 1)));

  // R2
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R7
  mode_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (double_mode != $past(double_mode)) |=> (out_data == '0));

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(rst) && ($past(double_mode) == $past(double_mode, 2)))
      |-> $stable(out_data));
endmodule

bind sinc_interp sinc_interp_chk #(.IN_W(IN_W), .DIV(DIV)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .double_mode (double_mode),
  .out_valid   (out_valid),
  .out_data    (out_data)
);

// File: tb/sinc_interp_tb.sv
module sinc_interp_tb;
  localparam int NSEQ = 12;
  localparam int signed SEQ [NSEQ] = '{
    4000, 4000, 4000, -8000, 32767, 32767, 32767,
    -32768, -32768, -32768, 17, -1
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        double_mode = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic [15:0] out_data;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sinc_interp u_dut (
    .clk         (clk),
    .rst         (rst),
    .double_mode (double_mode),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .out_valid   (out_valid),
    .out_data    (out_data)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int kern(input int r, input int k);
    if (k < 0 || k > 2 * r - 2) return 0;
    if (k < r) return k + 1;
    return 2 * r - 1 - k;
  endfunction

  // triangular-kernel sum from the requirements (R5)
  function automatic int model(input int r, input int lg, input int m);
    int s = 0;
    for (int j = 0; j < NSEQ; j++) s += SEQ[j] * kern(r, m - j * r);
    return s >>> lg;
  endfunction

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst = 1'b1;
    double_mode = mode;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic next_strobe();
    @(negedge clk);
    while (!out_valid) @(negedge clk);
  endtask

  task automatic run_table(input logic mode, input string req);
    int r  = mode ? 8 : 16;
    int lg = mode ? 3 : 4;
    do_reset(mode);
    next_strobe();
    for (int j = 0; j < NSEQ; j++) begin
      in_valid = 1'b1;
      in_data  = 16'(SEQ[j]);
      for (int k = 0; k < r; k++) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = 16'(~SEQ[j] ^ (k * 4099)); // R9 junk while in_valid low
        while (!out_valid) @(negedge clk);
        check(req, $signed(out_data), model(r, lg, j * r + k));
      end
    end
  endtask

  task automatic feed_const(input int a, input int r, input int n, input string req);
    for (int j = 0; j < n; j++) begin
      in_valid = 1'b1;
      in_data  = 16'(a);
      for (int k = 0; k < r; k++) begin
        int e;
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = 16'h5A5A;
        while (!out_valid) @(negedge clk);
        e = (j == 0) ? ((a * (k + 1)) >>> $clog2(r)) : a;
        if (j == 0 || k == r - 1) check(req, $signed(out_data), e);
      end
    end
  endtask

  initial begin
    // R1 reset state
    repeat (2) @(negedge clk);
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 out_data", int'(out_data), 0);

    // R5 R9 table, normal then double
    run_table(1'b0, "R5/R3 normal table");
    run_table(1'b1, "R5/R4 double table");

    // R3 R6 normal step, full scale
    do_reset(1'b0); next_strobe();
    feed_const(32767, 16, 3, "R3/R6 normal +fs");
    do_reset(1'b0); next_strobe();
    feed_const(-32768, 16, 3, "R6 normal -fs");
    // R4 R6 double step
    do_reset(1'b1); next_strobe();
    feed_const(-32768, 8, 3, "R4/R6 double -fs");
    do_reset(1'b1); next_strobe();
    feed_const(32767, 8, 3, "R6 double +fs");

    // R2 strobe spacing across a mode change, R7 clear, R8 hold
    begin
      int last;
      do_reset(1'b0); next_strobe();
      feed_const(1200, 16, 2, "R3 pre-switch");
      last = cyc;
      for (int i = 0; i < 4; i++) begin
        next_strobe();
        check("R2 spacing normal", cyc - last, 6);
        last = cyc;
      end
      @(negedge clk);
      double_mode = 1'b1;
      @(negedge clk);
      check("R7 cleared", int'(out_data), 0);
      next_strobe();
      check("R2 spacing across switch", cyc - last, 6);
      last = cyc;
      for (int i = 0; i < 4; i++) begin
        next_strobe();
        check("R2 spacing double", cyc - last, 6);
        check("R7 stays zero", int'(out_data), 0);
        last = cyc;
      end
      feed_const(800, 8, 2, "R7 fresh ramp");
      for (int i = 0; i < 5; i++) begin
        logic [15:0] held;
        held = out_data;
        @(negedge clk);
        check("R8 hold", int'(out_data), int'(held));
      end
    end

    // R1 reset mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run out_data", int'(out_data), 0);
    check("R1 mid-run out_valid", int'(out_valid), 0);
    rst = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule